// File: doc/BRIEF.md
# Keyed Operand Entry Multiplier

This block multiplies two unsigned nibbles that arrive one after the other on a shared input bus. It is meant to sit behind a keypad front end. Each operand is taken when the front end raises a data-valid strobe. The block then waits for a confirm press before it moves on. After the second confirm, the product is built by shift-and-add, one partial product per clock, from the least significant multiplier bit upward. The result appears on a registered output together with a single-cycle completion pulse.

All state, operand and result registers run on the one system clock and use a synchronous, active-high reset. No storage element is enabled by a derived clock, and no storage is inferred outside the clocked processes. The strobe and the confirm input must already be synchronised to the clock and free of bounce.

Top module: `opnd_entry_mult`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `product` to 0, `done` to 0 and both operand registers, and it returns to its start state. One clock after `rst` falls, it is ready to accept the first operand.
- R2: In the first-operand wait state, a rising edge with `nib_valid` high loads `nib_in` as the multiplicand. The block then waits for confirm.
- R3: In either confirm-wait state the block stays put for any number of cycles while `confirm` is low. During that time `done` stays 0 and `product` does not change. A single cycle with `confirm` high is enough to advance.
- R4: In the second-operand wait state, a rising edge with `nib_valid` high loads `nib_in` as the multiplier.
- R5: `nib_valid` is ignored in every state other than the two operand wait states: in the confirm waits and during the computation it changes neither operand.
- R6: The result is the full 8-bit unsigned product of the two operands, formed as the sum over multiplier bits i = 0..3 of the multiplicand shifted left by i where bit i is 1. For example 11 x 14 = 154, 15 x 15 = 225, and a zero operand gives 0.
- R7: `product` takes its new value, and `done` goes to 1, on the 4th rising edge after the edge that samples `confirm` high in the second confirm wait. `done` is high for exactly one cycle.
- R8: `product` keeps its last value until the next computation completes, including while new operands are being entered.
- R9: After the completion edge the block is back in the first-operand wait state, so the next `nib_valid` starts a new multiplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nib_in | input | 4 | Shared operand bus |
| nib_valid | input | 1 | Data-valid strobe for `nib_in` |
| confirm | input | 1 | Confirm press, already synchronised and debounced |
| product | output | 8 | Registered product |
| done | output | 1 | One-cycle pulse when a new product is loaded |

## Verification
The multiply is tried with several operand pairs:
- 11 x 14 exercises a mixed bit pattern in the multiplier.
- 15 x 15 drives the carry into the top product bit.
- A zero multiplicand and a zero multiplier each give a product of zero.

Slow confirms show that the block waits for the press and does not time out. Stray strobes carrying different nibbles are sent during both confirm waits and during the computation; a wrong product exposes any capture outside the two operand wait states. A reset in the middle of the computation, followed by a fresh entry, separates the reset clearing from the hold behaviour of the result register.

// File: rtl/mult_entry_pkg.sv
package mult_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_RST = 3'd0,
    ST_GET_A    = 3'd1,
    ST_ACK_A    = 3'd2,
    ST_GET_B    = 3'd3,
    ST_ACK_B    = 3'd4,
    ST_CALC     = 3'd5
  } entry_st_t;
endpackage

// File: rtl/entry_fsm.sv
module entry_fsm
  import mult_entry_pkg::*;
#(
  parameter int OPW = 4,
  localparam int CW = (OPW > 1) ? $clog2(OPW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nib_valid,
  input  logic          confirm,
  output entry_st_t     st,
  output logic          ld_a,
  output logic          ld_b,
  output logic          calc_start,
  output logic          calc_en,
  output logic          calc_last,
  output logic [CW-1:0] step_idx
);
  localparam logic [CW-1:0] LAST_STEP = CW'(OPW - 1);

  logic [CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE_RST;
      idx_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE_RST: st <= ST_GET_A;
        ST_GET_A:    if (nib_valid) st <= ST_ACK_A;
        ST_ACK_A:    if (confirm)   st <= ST_GET_B;
        ST_GET_B:    if (nib_valid) st <= ST_ACK_B;
        ST_ACK_B: begin
          if (confirm) begin
            st    <= ST_CALC;
            idx_q <= '0;
          end
        end
        ST_CALC: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_STEP) st <= ST_GET_A;
        end
        default: st <= ST_IDLE_RST;
      endcase
    end
  end

  always_comb begin
    ld_a       = (st == ST_GET_A) && nib_valid;
    ld_b       = (st == ST_GET_B) && nib_valid;
    calc_start = (st == ST_ACK_B) && confirm;
    calc_en    = (st == ST_CALC);
    calc_last  = calc_en && (idx_q == LAST_STEP);
    step_idx   = idx_q;
  end
endmodule

// File: rtl/operand_store.sv
module operand_store #(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] nib_in,
  input  logic           ld_a,
  input  logic           ld_b,
  output logic [OPW-1:0] op_a,
  output logic [OPW-1:0] op_b
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0]          slot_ld;
  logic [NSLOT-1:0][OPW-1:0] slot_q;

  assign slot_ld = {ld_b, ld_a};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)             slot_q[s] <= '0;
      else if (slot_ld[s]) slot_q[s] <= nib_in;
    end
  end

  assign op_a = slot_q[0];
  assign op_b = slot_q[1];
endmodule

// File: rtl/shift_add_acc.sv
module shift_add_acc #(
  parameter int OPW = 4,
  localparam int PW = 2 * OPW,
  localparam int CW = (OPW > 1) ? $clog2(OPW) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic           calc_start,
  input  logic           calc_en,
  input  logic           calc_last,
  input  logic [CW-1:0]  step_idx,
  output logic [PW-1:0]  product,
  output logic           done
);
  // One partial product: the multiplicand, widened and shifted by the
  // position of the selected multiplier bit, or zero when that bit is 0.
  function automatic logic [PW-1:0] part_term(input logic [OPW-1:0] a,
                                              input logic [OPW-1:0] b,
                                              input logic [CW-1:0]  i);
    logic [PW-1:0] wide;
    wide = '0;
    wide[OPW-1:0] = a;
    return b[i] ? (wide << i) : '0;
  endfunction

  logic [PW-1:0] acc_q;
  logic [PW-1:0] acc_nx;

  assign acc_nx = acc_q + part_term(op_a, op_b, step_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (calc_start) begin
        acc_q <= '0;
      end else if (calc_en) begin
        acc_q <= acc_nx;
        if (calc_last) begin
          product <= acc_nx;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/opnd_entry_mult.sv
module opnd_entry_mult
  import mult_entry_pkg::*;
#(
  parameter int OPW = 4,
  localparam int PW = 2 * OPW,
  localparam int CW = (OPW > 1) ? $clog2(OPW) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] nib_in,
  input  logic           nib_valid,
  input  logic           confirm,
  output logic [PW-1:0]  product,
  output logic           done
);
  // Internal events brought out as named wires for the checker.
  entry_st_t      st;
  logic           ld_a;
  logic           ld_b;
  logic           calc_start;
  logic           calc_en;
  logic           calc_last;
  logic [CW-1:0]  step_idx;
  logic [OPW-1:0] op_a;
  logic [OPW-1:0] op_b;

  entry_fsm #(.OPW(OPW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .nib_valid  (nib_valid),
    .confirm    (confirm),
    .st         (st),
    .ld_a       (ld_a),
    .ld_b       (ld_b),
    .calc_start (calc_start),
    .calc_en    (calc_en),
    .calc_last  (calc_last),
    .step_idx   (step_idx)
  );

  operand_store #(.OPW(OPW)) u_ops (
    .clk    (clk),
    .rst    (rst),
    .nib_in (nib_in),
    .ld_a   (ld_a),
    .ld_b   (ld_b),
    .op_a   (op_a),
    .op_b   (op_b)
  );

  shift_add_acc #(.OPW(OPW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .op_a       (op_a),
    .op_b       (op_b),
    .calc_start (calc_start),
    .calc_en    (calc_en),
    .calc_last  (calc_last),
    .step_idx   (step_idx),
    .product    (product),
    .done       (done)
  );
endmodule

// File: rtl/opnd_entry_mult_chk.sv
module opnd_entry_mult_chk
  import mult_entry_pkg::*;
#(
  parameter int OPW = 4,
  localparam int PW = 2 * OPW
) (
  input logic           clk,
  input logic           rst,
  input logic           nib_valid,
  input logic           confirm,
  input entry_st_t      st,
  input logic           ld_a,
  input logic           ld_b,
  input logic [OPW-1:0] op_a,
  input logic [OPW-1:0] op_b,
  input logic [PW-1:0]  product,
  input logic           done
);
  logic [PW-1:0] ref_prod;
  assign ref_prod = PW'(op_a) * PW'(op_b);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (product == '0) && !done && (op_a == '0) && (op_b == '0));

  // R3
  a_r3_wait_confirm_a: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK_A) && !confirm |=> (st == ST_ACK_A));
  a_r3_wait_confirm_b: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK_B) && !confirm |=> (st == ST_ACK_B) && !done);

  // R5
  a_r5_no_stray_load: assert property (@(posedge clk) disable iff (rst)
    (ld_a || ld_b) |-> nib_valid && ((st == ST_GET_A) || (st == ST_GET_B)));
  a_r5_ops_held_in_calc: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC) |=> $stable(op_a) && $stable(op_b));

  // R6
  a_r6_product_value: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == ref_prod));

  // R7
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_after_calc: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(st) == ST_CALC));

  // R8
  a_r8_product_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> done);

  // R9
  a_r9_back_to_a: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == ST_GET_A));
endmodule

bind opnd_entry_mult opnd_entry_mult_chk #(.OPW(OPW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nib_valid (nib_valid),
  .confirm   (confirm),
  .st        (st),
  .ld_a      (ld_a),
  .ld_b      (ld_b),
  .op_a      (op_a),
  .op_b      (op_b),
  .product   (product),
  .done      (done)
);

// File: tb/test_opnd_entry_mult.sv
`timescale 1ns/1ps
module test_opnd_entry_mult;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] nib_in = '0;
  logic       nib_valid = 1'b0;
  logic       confirm = 1'b0;
  logic [7:0] product;
  logic       done;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  opnd_entry_mult i_opnd_entry_mult (
    .clk       (clk),
    .rst       (rst),
    .nib_in    (nib_in),
    .nib_valid (nib_valid),
    .confirm   (confirm),
    .product   (product),
    .done      (done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Every helper starts and ends just after a falling edge.
  task automatic strobe(input logic [3:0] v);
    nib_in = v; nib_valid = 1'b1;
    @(negedge clk);
    nib_valid = 1'b0; nib_in = 4'h0;
  endtask

  task automatic press();
    confirm = 1'b1;
    @(negedge clk);
    confirm = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Compute step: 4 edges after the confirm edge, then a one-cycle pulse.
  task automatic finish_calc(input string tag, input int exp_p, input int old_p);
    idle(3);
    chk({tag, " R7 done not early"}, int'(done), 0);
    chk({tag, " R8 product held"}, int'(product), old_p);
    idle(1);
    chk({tag, " R7 done pulse"}, int'(done), 1);
    chk({tag, " R6 product"}, int'(product), exp_p);
    idle(1);
    chk({tag, " R7 done one cycle"}, int'(done), 0);
    chk({tag, " R8 product after done"}, int'(product), exp_p);
  endtask

  task automatic run_mult(input string tag, input logic [3:0] a, input logic [3:0] b);
    int old_p;
    old_p = int'(product);
    strobe(a);   // R2
    press();
    strobe(b);   // R4
    press();
    finish_calc(tag, int'(a) * int'(b), old_p);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    chk("R1 reset product", int'(product), 0);
    chk("R1 reset done", int'(done), 0);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_basic();
    run_mult("basic 11x14", 4'd11, 4'd14);
    chk("R6 11x14=154", int'(product), 154);
  endtask

  task automatic t_corners();
    run_mult("max 15x15", 4'd15, 4'd15);
    run_mult("zero A", 4'd0, 4'd9);
    run_mult("zero B", 4'd9, 4'd0);
    run_mult("one", 4'd1, 4'd13);
  endtask

  task automatic t_slow_confirm();
    int old_p;
    old_p = int'(product);
    strobe(4'd6);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R3 wait A no done", int'(done), 0);
    end
    press();
    strobe(4'd7);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R3 wait B product held", int'(product), old_p);
    end
    press();
    finish_calc("slow confirm R3", 42, old_p);
  endtask

  task automatic t_ignore();
    int old_p;
    old_p = int'(product);
    strobe(4'd3);
    strobe(4'd15);   // R5: confirm wait A
    press();
    strobe(4'd5);
    strobe(4'd12);   // R5: confirm wait B
    confirm = 1'b1;
    @(negedge clk);
    confirm = 1'b0;
    strobe(4'd9);    // R5: during computation
    strobe(4'd10);
    idle(1);
    chk("R5 stray strobes no early done", int'(done), 0);
    idle(1);
    chk("R5 stray strobes ignored", int'(product), 15);
    chk("R5 done", int'(done), 1);
    idle(1);
    if (old_p == 15) chk("R5 old differs", 0, 1);
  endtask

  task automatic t_back_to_back();
    // R9: the strobe right after the pulse cycle is taken as a new multiplicand
    run_mult("R9 first", 4'd2, 4'd4);
    run_mult("R9 second", 4'd13, 4'd12);
    chk("R9 13x12=156", int'(product), 156);
  endtask

  task automatic t_reset_mid();
    strobe(4'd14);
    press();
    strobe(4'd11);
    press();
    idle(1);
    t_reset();
    chk("R1 mid reset no done", int'(done), 0);
    run_mult("R1 after mid reset", 4'd10, 4'd7);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_corners();
    t_slow_confirm();
    t_ignore();
    t_back_to_back();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule